// File: doc/BRIEF.md
# DS3 PLCP Frame Generator

This block builds the transmit-side convergence frames that carry ATM cells over a DS3 payload. It runs without stopping once reset is released and emits one byte per clock. Each frame has twelve rows. A row is made of two alignment bytes, a row identifier, one path overhead byte and one 53-byte cell. A nibble trailer follows the last row. The byte stream goes to a DS3 framer, and markers show where each frame starts, which bytes are overhead, and when only the upper nibble of a byte is meaningful.

Cell bytes come from an external source. The block asks for a byte with `cell_take`, flags the first byte of every cell with `cell_sop`, and samples `cell_data` at the next rising edge.

The block decides the trailer length by itself, using a fixed three-frame stuffing cycle. It also computes bit-interleaved parity over the previous frame. From the local receive side it takes a block error count and a yellow alarm request and carries them in a status byte back to the far end.

Top module: `plcp_frame_gen`

## Requirements
- R1: While `rst_n` is low, `o_byte`, `o_sof`, `o_oh`, `o_half` and `cell_take` are all 0. The first clock edge after release produces the first byte of a frame, so `o_sof` is seen high at the second falling edge after release.
- R2: Every row begins with 0xF6, then 0x28, then a row identifier. The identifiers run 0x2C, 0x29, 0x25, 0x20, 0x1C, 0x19, 0x15, 0x10, 0x0D, 0x08, 0x04, 0x01 from the first row to the last. These three bytes and the path overhead byte have `o_oh` set, and `o_sof` marks the first 0xF6 of the frame.
- R3: Each frame carries exactly 12 cells of 53 bytes. The cell bytes appear in request order with `o_oh` low, and `cell_sop` pulses once per cell.
- R4: The path overhead byte is 0x00 in rows 1 to 7, 10 and 11 (counting from 1). Row 8 carries the parity byte, row 9 the status byte and row 12 the cycle byte.
- R5: The parity byte is the even parity of each bit position taken over the path overhead and cell bytes (54 per row, 648 in total) of the previous frame. It is 0x00 in the first frame after reset.
- R6: Frames follow a repeating three-phase stuffing cycle that starts at phase 0 after reset. The cycle byte is 0xFF in phase 0 (13-nibble trailer), 0x00 in phase 1 (14-nibble trailer) and 0x66 in phase 2 (13-nibble trailer).
- R7: A 14-nibble trailer is seven 0xCC bytes. A 13-nibble trailer is six 0xCC bytes and then 0xC0 with `o_half` high. All trailer bytes have `o_oh` set, and `o_half` is high nowhere else.
- R8: Status byte bits [7:4] hold the error count: `rx_febe_cnt` when `rx_febe_vld` is high, clamped to 8 above 8, and 15 when `rx_febe_vld` is low. Bits [2:0] are 0.
- R9: Status byte bit 3 equals `rx_yellow` as sampled while the status byte is produced.
- R10: Every frame lasts 691 output bytes, and `o_sof` is high on the first byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_data | input | 8 | Cell byte offered by the source, sampled when `cell_take` is high |
| cell_take | output | 1 | The current cycle consumes one cell byte |
| cell_sop | output | 1 | The byte consumed this cycle is the first byte of a cell |
| rx_febe_cnt | input | 4 | Block error count from the local receiver |
| rx_febe_vld | input | 1 | Error count is in use |
| rx_yellow | input | 1 | Yellow alarm request from the local receiver |
| o_byte | output | 8 | Frame byte |
| o_sof | output | 1 | First byte of a frame |
| o_oh | output | 1 | Byte is overhead or trailer |
| o_half | output | 1 | Only the upper nibble of `o_byte` is valid |

## Verification
If the column counter is off, a misplaced 0xF6/0x28 pair shows up within one row, which is at most 57 bytes. A corrupted row counter shows as a wrong identifier byte at the next row start. If the stuffing phase is wrong, the frame's cycle byte and its trailer disagree with the expected cycle within that same frame. A fault in the parity accumulator only appears one frame later, in the parity byte of the next frame. This is why the bench checks every frame in a run of consecutive frames, not single frames in isolation.

// File: rtl/plcp_pkg.sv
package plcp_pkg;

  localparam logic [7:0] ALIGN_HI   = 8'hF6;
  localparam logic [7:0] ALIGN_LO   = 8'h28;
  localparam logic [7:0] FILL_PAIR  = 8'hCC;
  localparam logic [7:0] FILL_HALF  = 8'hC0;
  localparam logic [3:0] FEBE_MAX   = 4'd8;
  localparam logic [3:0] FEBE_NONE  = 4'hF;

  // Row identifier: row number in bits [5:2], bit 0 gives odd parity over it.
  function automatic logic [7:0] poi_code(input logic [3:0] n);
    return {2'b00, n, 1'b0, ~^n};
  endfunction

  function automatic logic [3:0] febe_code(input logic [3:0] cnt, input logic vld);
    if (!vld)                 return FEBE_NONE;
    else if (cnt > FEBE_MAX)  return FEBE_MAX;
    else                      return cnt;
  endfunction

  function automatic logic [7:0] cycle_code(input logic [1:0] ph);
    case (ph)
      2'd0:    return 8'hFF;
      2'd1:    return 8'h00;
      default: return 8'h66;
    endcase
  endfunction

  // Phase 1 is the long (14-nibble) trailer frame.
  function automatic logic long_trailer(input logic [1:0] ph);
    return ph == 2'd1;
  endfunction

endpackage

// File: rtl/plcp_slot_ctr.sv
module plcp_slot_ctr #(
  parameter int ROWS      = 12,
  parameter int ROW_BYTES = 57,
  parameter int TRL_BYTES = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  output logic [$clog2(ROWS+1)-1:0]      row,
  output logic [$clog2(ROW_BYTES)-1:0]   col,
  output logic [1:0]                     phase,
  output logic                           in_trl,
  output logic                           frame_end
);
  localparam int RW = $clog2(ROWS+1);
  localparam int CW = $clog2(ROW_BYTES);
  localparam logic [RW-1:0] TRL_ROW = RW'(ROWS);
  localparam logic [CW-1:0] COL_END = CW'(ROW_BYTES-1);
  localparam logic [CW-1:0] TRL_END = CW'(TRL_BYTES-1);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [1:0]    ph_q;
  logic          row_end;

  assign in_trl    = (row_q == TRL_ROW);
  assign frame_end = in_trl && (col_q == TRL_END);
  assign row_end   = !in_trl && (col_q == COL_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      ph_q  <= '0;
    end else if (frame_end) begin
      row_q <= '0;
      col_q <= '0;
      ph_q  <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
    end else if (row_end) begin
      row_q <= row_q + 1'b1;
      col_q <= '0;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign row   = row_q;
  assign col   = col_q;
  assign phase = ph_q;

  assert_col_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_trl |-> col_q <= COL_END);
  assert_col_in_trl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_trl |-> col_q <= TRL_END);
  assert_phase_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3);
  assert_phase_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(ph_q));
endmodule

// File: rtl/plcp_bip8.sv
module plcp_bip8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] din,
  input  logic       frame_end,
  output logic [7:0] b1
);
  logic [7:0] acc_q;
  logic [7:0] b1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b1_q  <= '0;
    end else if (frame_end) begin
      b1_q  <= acc_q;
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_q ^ din;
    end
  end

  assign b1 = b1_q;

  assert_b1_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(b1_q));
  assert_no_accum_in_trailer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> acc_q == 8'h00 || en);
endmodule

// File: rtl/plcp_frame_gen.sv
module plcp_frame_gen #(
  parameter int ROWS       = 12,
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cell_data,
  output logic       cell_take,
  output logic       cell_sop,
  input  logic [3:0] rx_febe_cnt,
  input  logic       rx_febe_vld,
  input  logic       rx_yellow,
  output logic [7:0] o_byte,
  output logic       o_sof,
  output logic       o_oh,
  output logic       o_half
);
  import plcp_pkg::*;

  localparam int ROW_BYTES = CELL_BYTES + 4;
  localparam int TRL_BYTES = 7;
  localparam int RW = $clog2(ROWS+1);
  localparam int CW = $clog2(ROW_BYTES);
  localparam logic [RW-1:0] ROW_B1  = RW'(ROWS-5);
  localparam logic [RW-1:0] ROW_G1  = RW'(ROWS-4);
  localparam logic [RW-1:0] ROW_C1  = RW'(ROWS-1);
  localparam logic [RW-1:0] POI_TOP = RW'(ROWS-1);
  localparam logic [CW-1:0] COL_A2  = CW'(1);
  localparam logic [CW-1:0] COL_POI = CW'(2);
  localparam logic [CW-1:0] COL_POH = CW'(3);
  localparam logic [CW-1:0] COL_CEL = CW'(4);
  localparam logic [CW-1:0] TRL_END = CW'(TRL_BYTES-1);

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [1:0]    phase;
  logic          in_trl, frame_end;
  logic [7:0]    b1, poh_byte, g1_byte, slot_byte;
  logic [RW-1:0] poi_idx;
  logic          slot_oh, slot_half, slot_sof, bip_en, g1_slot;

  plcp_slot_ctr #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .TRL_BYTES(TRL_BYTES)) ctr_i (
    .clk(clk), .rst_n(rst_n), .row(row), .col(col), .phase(phase),
    .in_trl(in_trl), .frame_end(frame_end)
  );

  assign poi_idx = POI_TOP - row;
  assign g1_byte = {febe_code(rx_febe_cnt, rx_febe_vld), rx_yellow, 3'b000};
  assign g1_slot = !in_trl && (row == ROW_G1) && (col == COL_POH);

  always_comb begin
    if      (row == ROW_B1) poh_byte = b1;
    else if (row == ROW_G1) poh_byte = g1_byte;
    else if (row == ROW_C1) poh_byte = cycle_code(phase);
    else                    poh_byte = 8'h00;
  end

  always_comb begin
    slot_half = 1'b0;
    slot_oh   = 1'b1;
    cell_take = 1'b0;
    if (in_trl) begin
      slot_half = (col == TRL_END) && !long_trailer(phase);
      slot_byte = slot_half ? FILL_HALF : FILL_PAIR;
    end else if (col == '0) begin
      slot_byte = ALIGN_HI;
    end else if (col == COL_A2) begin
      slot_byte = ALIGN_LO;
    end else if (col == COL_POI) begin
      slot_byte = poi_code(4'(poi_idx));
    end else if (col == COL_POH) begin
      slot_byte = poh_byte;
    end else begin
      slot_byte = cell_data;
      slot_oh   = 1'b0;
      cell_take = 1'b1;
    end
  end

  assign cell_sop = !in_trl && (col == COL_CEL);
  assign slot_sof = (row == '0) && (col == '0);
  assign bip_en   = !in_trl && (col >= COL_POH);

  plcp_bip8 bip_i (
    .clk(clk), .rst_n(rst_n), .en(bip_en), .din(slot_byte),
    .frame_end(frame_end), .b1(b1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_byte <= '0;
      o_sof  <= 1'b0;
      o_oh   <= 1'b0;
      o_half <= 1'b0;
    end else begin
      o_byte <= slot_byte;
      o_sof  <= slot_sof;
      o_oh   <= slot_oh;
      o_half <= slot_half;
    end
  end

  assert_sof_is_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    o_sof |-> (o_oh && o_byte == ALIGN_HI));
  assert_half_ends_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    o_half |=> o_sof);
  assert_half_is_oh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    o_half |-> (o_oh && o_byte == FILL_HALF));
  assert_take_not_trailer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_take |=> !o_oh);
  assert_febe_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    g1_slot |-> (g1_byte[7:4] <= FEBE_MAX || g1_byte[7:4] == FEBE_NONE));
endmodule

// File: tb/plcp_frame_gen_tb.sv
module plcp_frame_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWB = 57;
  localparam int FLEN = 691;

  // {febe_cnt[3:0], febe_vld, yellow, expected status byte[7:0]}
  localparam int NVEC = 6;
  localparam logic [13:0] VEC [NVEC] = '{
    {4'd0,  1'b1, 1'b0, 8'h00},
    {4'd5,  1'b1, 1'b1, 8'h58},
    {4'd8,  1'b1, 1'b0, 8'h80},
    {4'd12, 1'b1, 1'b1, 8'h88},
    {4'd3,  1'b0, 1'b0, 8'hF0},
    {4'd15, 1'b1, 1'b1, 8'h88}
  };
  localparam logic [7:0] POI_TAB [12] = '{
    8'h2C, 8'h29, 8'h25, 8'h20, 8'h1C, 8'h19,
    8'h15, 8'h10, 8'h0D, 8'h08, 8'h04, 8'h01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cell_data = 8'h00;
  logic cell_take, cell_sop;
  logic [3:0] rx_febe_cnt = 4'd0;
  logic rx_febe_vld = 1'b0;
  logic rx_yellow = 1'b0;
  logic [7:0] o_byte;
  logic o_sof, o_oh, o_half;

  int n_chk = 0;
  int n_fail = 0;
  int seq = 0;
  int expc = 0;
  int sops = 0;
  logic [7:0] prev_par = 8'h00;
  logic [7:0] fb [1024];
  logic fo [1024];
  logic fh [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  plcp_frame_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cell_data(cell_data), .cell_take(cell_take),
    .cell_sop(cell_sop), .rx_febe_cnt(rx_febe_cnt), .rx_febe_vld(rx_febe_vld),
    .rx_yellow(rx_yellow), .o_byte(o_byte), .o_sof(o_sof), .o_oh(o_oh),
    .o_half(o_half)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Cell source: new byte offered at each falling edge where one is requested.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) seq = 0;
      else if (cell_take) begin
        cell_data = seq[7:0];
        seq++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    finish_run();
  end

  task automatic collect(output int len);
    int guard = 0;
    len = 0;
    sops = 0;
    do begin
      fb[len] = o_byte; fo[len] = o_oh; fh[len] = o_half;
      if (cell_sop) sops++;
      len++;
      @(negedge clk);
      guard++;
    end while (!o_sof && guard < 1000);
    if (guard >= 1000) chk(1'b0, "R10 frame timeout", guard, FLEN);
  endtask

  task automatic check_frame(input int len, input int fidx, input logic [7:0] exp_g1);
    int ph = fidx % 3;
    int bad_frm = 0, bad_flag = 0, bad_cell = 0, bad_zero = 0, bad_trl = 0;
    logic [7:0] par = 8'h00;
    logic [7:0] exp_b1 = (fidx == 0) ? 8'h00 : prev_par;
    logic [7:0] exp_c1 = (ph == 0) ? 8'hFF : (ph == 1) ? 8'h00 : 8'h66;
    chk(len == FLEN, "R10 frame length", len, FLEN);
    chk(sops == 12, "R3 cell starts per frame", sops, 12);
    for (int r = 0; r < 12; r++) begin
      int b = r * ROWB;
      if (fb[b] != 8'hF6 || fb[b+1] != 8'h28 || fb[b+2] != POI_TAB[r]) bad_frm++;
      if (!fo[b] || !fo[b+1] || !fo[b+2] || !fo[b+3] || fh[b+3]) bad_flag++;
      if (r != 7 && r != 8 && r != 11 && fb[b+3] != 8'h00) bad_zero++;
      for (int c = 3; c < ROWB; c++) par = par ^ fb[b+c];
      for (int c = 4; c < ROWB; c++) begin
        if (fo[b+c] || fh[b+c] || fb[b+c] != expc[7:0]) bad_cell++;
        expc++;
      end
    end
    chk(bad_frm == 0, "R2 align and identifier bytes", bad_frm, 0);
    chk(bad_flag == 0, "R2 overhead flags", bad_flag, 0);
    chk(bad_zero == 0, "R4 unused overhead bytes", bad_zero, 0);
    chk(bad_cell == 0, "R3 cell bytes in order", bad_cell, 0);
    chk(fb[7*ROWB+3] == exp_b1, "R5 parity byte", fb[7*ROWB+3], exp_b1);
    chk(fb[11*ROWB+3] == exp_c1, "R6 cycle byte", fb[11*ROWB+3], exp_c1);
    chk(fb[8*ROWB+3][7:4] == exp_g1[7:4] && fb[8*ROWB+3][2:0] == 3'b000,
        "R8 error count field", fb[8*ROWB+3], exp_g1);
    chk(fb[8*ROWB+3][3] == exp_g1[3], "R9 yellow bit", fb[8*ROWB+3][3], exp_g1[3]);
    for (int t = 684; t < FLEN; t++) begin
      bit last_half = (t == FLEN-1) && (ph != 1);
      if (!fo[t] || fh[t] != last_half || fb[t] != (last_half ? 8'hC0 : 8'hCC)) bad_trl++;
    end
    chk(bad_trl == 0, "R7 trailer nibbles", bad_trl, 0);
    prev_par = par;
  endtask

  task automatic reset_and_sync();
    int waits = 0;
    @(posedge clk); #(CLK_PERIOD/4);
    rst_n = 1'b0;
    expc = 0;
    repeat (3) @(negedge clk);
    chk(o_byte == 8'h00 && !o_sof && !o_oh && !o_half && !cell_take,
        "R1 outputs in reset", {o_byte, o_sof, o_oh, o_half, cell_take}, 0);
    @(posedge clk); #(CLK_PERIOD/4);
    rst_n = 1'b1;
    do begin
      @(negedge clk);
      waits++;
    end while (!o_sof && waits < 100);
    chk(waits == 2, "R1 first frame start after release", waits, 2);
  endtask

  initial begin
    int len;
    int fidx;
    repeat (2) @(negedge clk);
    reset_and_sync();
    fidx = 0;
    for (int i = 0; i < NVEC; i++) begin
      rx_febe_cnt = VEC[i][13:10];
      rx_febe_vld = VEC[i][9];
      rx_yellow   = VEC[i][8];
      collect(len);
      check_frame(len, fidx, VEC[i][7:0]);
      fidx++;
    end
    // Reset in mid-frame: cycle restarts at phase 0, parity byte clears.
    repeat (200) @(negedge clk);
    reset_and_sync();
    rx_febe_cnt = 4'd9; rx_febe_vld = 1'b1; rx_yellow = 1'b1;
    collect(len);
    check_frame(len, 0, 8'h88);
    rx_febe_cnt = 4'd1; rx_febe_vld = 1'b1; rx_yellow = 1'b0;
    collect(len);
    check_frame(len, 1, 8'h10);
    finish_run();
  end
endmodule